// File: doc/BRIEF.md
# Multiplexed Nibble Register Bus Interface

This block sits between a host processor and the register file of a timekeeping peripheral. The host reaches sixteen 4-bit registers over a narrow bus. A 4-bit address is held by an address-latch strobe. A 4-bit data bus carries both directions. Separate active-low read and write strobes mark each access. Two chip selects of opposite polarity must both be asserted before any access is honoured.

The address latch holds the address that was present at the last clock edge where the strobe was high. While the strobe is high, the latch passes the address straight through, so a host without an address-latch output can tie it high. The block gives the register file two things. The first is a read select, which is the effective address. The second is a write interface: a one-hot per-register write-enable pulse and the captured write nibble. On a read, the block drives the data bus through an output-enable signal.

All host inputs are taken as synchronous to `clk_i`. A write is committed once, after the write strobe is released. The commit uses the address, data and selects that were sampled at the last clock edge where the strobe was still active.

Top module: `nib_bus_if`

## Requirements
- R1: During and right after reset, `wr_en_o` is all zero, `wr_data_o` is zero and `data_oe_o` is low.
- R2: While `ale_i` is high, `rd_sel_o` equals `addr_i` in the same cycle. While `ale_i` is low, `rd_sel_o` keeps the `addr_i` value that was sampled at the last rising clock edge where `ale_i` was high.
- R3: An access is selected only when `cs_hi_i` is 1 and `cs_lo_ni` is 0 at the same time. In any other chip-select combination, no write enable fires and `data_oe_o` stays low.
- R4: A committed write asserts exactly one bit of `wr_en_o`, bit n for register address n (0x0 to 0xF). At all other times, no bit is set.
- R5: `wr_en_o` is high for the one cycle that follows the first rising edge at which `wr_ni` is sampled high after being sampled low. `wr_data_o` then holds `data_i` as it was at the last edge where `wr_ni` was low. The register address is the effective address at that same edge.
- R6: A write pulse lasting any number of cycles gives exactly one `wr_en_o` pulse.
- R7: `data_oe_o` is high only while `rd_ni` is 0, the block is selected and `wr_ni` is 1. During that time `data_o` equals `reg_rdata_i`. Otherwise `data_o` is 0.
- R8: If `rd_ni` is sampled low at any edge during a write pulse, that write is dropped: no `wr_en_o` bit fires. `data_oe_o` also stays low while both strobes are active.
- R9: The chip selects are qualified at the last edge of the write pulse. A write whose selects are invalid at that edge does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address latch strobe; high = transparent |
| cs_hi_i | input | 1 | Chip select, active high |
| cs_lo_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Register address from the host |
| data_i | input | 4 | Data bus, host to block |
| data_o | output | 4 | Data bus, block to host |
| data_oe_o | output | 1 | Data bus output enable |
| rd_sel_o | output | 4 | Read-mux select to the register file |
| reg_rdata_i | input | 4 | Selected register nibble from the register file |
| wr_en_o | output | 16 | One-hot register write enables |
| wr_data_o | output | 4 | Nibble to be written |

## Verification
The bench drives writes to the end addresses 0x0 and 0xF, and to addresses in between. It tries each invalid chip-select pair and uses strobes several cycles long. A write that fires on the falling strobe, or once per active cycle, shows up as a wrong pulse count or an early pulse. A write that takes the data from the edge of release instead of the last active edge shows up as a wrong data value when the data changes within the pulse. The bench also checks that the latch holds its address once `ale_i` drops. An edge-triggered latch, or a latch that never becomes transparent, would send the write or the read to the wrong register. Reads that overlap a write strobe, and reads with a bad chip select, must leave the bus released. A decoder that ignored either condition would drive `data_o` or commit the write anyway.

// File: rtl/nib_bus_pkg.sv
package nib_bus_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned NREG   = 1 << ADDR_W;
endpackage

// File: rtl/nib_addr_latch.sv
module nib_addr_latch #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (ale_i) addr_q <= addr_i;
  end

  // transparent while strobe high
  assign addr_o = ale_i ? addr_i : addr_q;

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(addr_q));
endmodule

// File: rtl/nib_wr_ctrl.sv
module nib_wr_ctrl #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_act_i,
  input  logic          rd_act_i,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          wr_q, sel_q, clash_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          release_w;

  assign release_w = wr_q & ~wr_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      sel_q   <= 1'b0;
      clash_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      wr_q <= wr_act_i;
      if (wr_act_i) begin
        addr_q  <= addr_i;
        data_q  <= data_i;
        sel_q   <= sel_i;
        // clash history restarts with each new pulse
        clash_q <= (wr_q & clash_q) | rd_act_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      fire_o <= release_w & sel_q & ~clash_q;
      if (release_w) begin
        addr_o <= addr_q;
        data_o <= data_q;
      end
    end
  end

  assert_fire_after_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (!$past(wr_act_i) && $past(wr_act_i, 2)));

  assert_single_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/nib_wr_decode.sv
module nib_wr_decode #(
  parameter int unsigned AW   = 4,
  parameter int unsigned NREG = 16
) (
  input  logic            fire_i,
  input  logic [AW-1:0]   addr_i,
  output logic [NREG-1:0] wr_en_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_en_o[i] = fire_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/nib_bus_if.sv
module nib_bus_if #(
  parameter int unsigned AW   = nib_bus_pkg::ADDR_W,
  parameter int unsigned DW   = nib_bus_pkg::DATA_W,
  parameter int unsigned NREG = 1 << AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_i,
  input  logic            cs_hi_i,
  input  logic            cs_lo_ni,
  input  logic            rd_ni,
  input  logic            wr_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o,
  output logic            data_oe_o,
  output logic [AW-1:0]   rd_sel_o,
  input  logic [DW-1:0]   reg_rdata_i,
  output logic [NREG-1:0] wr_en_o,
  output logic [DW-1:0]   wr_data_o
);
  logic          sel_w, rd_act_w, wr_act_w, fire_w;
  logic [AW-1:0] eff_addr_w, wr_addr_w;

  assign sel_w    = cs_hi_i & ~cs_lo_ni;
  assign rd_act_w = ~rd_ni;
  assign wr_act_w = ~wr_ni;

  nib_addr_latch #(.AW(AW)) i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .addr_i (addr_i),
    .addr_o (eff_addr_w)
  );

  nib_wr_ctrl #(.AW(AW), .DW(DW)) i_wr_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_act_i (wr_act_w),
    .rd_act_i (rd_act_w),
    .sel_i    (sel_w),
    .addr_i   (eff_addr_w),
    .data_i   (data_i),
    .fire_o   (fire_w),
    .addr_o   (wr_addr_w),
    .data_o   (wr_data_o)
  );

  nib_wr_decode #(.AW(AW), .NREG(NREG)) i_dec (
    .fire_i  (fire_w),
    .addr_i  (wr_addr_w),
    .wr_en_o (wr_en_o)
  );

  assign rd_sel_o  = eff_addr_w;
  assign data_oe_o = sel_w & rd_act_w & ~wr_act_w;
  assign data_o    = data_oe_o ? reg_rdata_i : '0;

  assert_wr_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));

  assert_wr_selected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_o) |-> ($past(cs_hi_i, 2) && !$past(cs_lo_ni, 2)));

  assert_wr_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_o) |-> $past(rd_ni, 2));
endmodule

// File: tb/test_nib_bus_if.sv
module test_nib_bus_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b1, cs_hi = 1'b0, cs_lo_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0, din = '0, dout, rd_sel, rdata, wdata;
  logic        oe;
  logic [15:0] wr_en;
  int          checks = 0, errors = 0, fires = 0;

  always #2 clk = ~clk;

  // register file model: contents are a function of the select
  assign rdata = rd_sel ^ 4'hA;

  nib_bus_if i_nib_bus_if (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .cs_hi_i(cs_hi), .cs_lo_ni(cs_lo_n),
    .rd_ni(rd_n), .wr_ni(wr_n), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(oe), .rd_sel_o(rd_sel), .reg_rdata_i(rdata), .wr_en_o(wr_en),
    .wr_data_o(wdata)
  );

  always @(negedge clk) if (|wr_en) fires++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {addr, data, cs_hi, cs_lo_n, len}
  localparam logic [13:0] VEC [8] = '{
    {4'h0, 4'h5, 1'b1, 1'b0, 4'd1},
    {4'hF, 4'hA, 1'b1, 1'b0, 4'd1},
    {4'h7, 4'h3, 1'b0, 1'b0, 4'd1},
    {4'h9, 4'hC, 1'b1, 1'b1, 4'd1},
    {4'h4, 4'h9, 1'b1, 1'b0, 4'd4},
    {4'hC, 4'h0, 1'b1, 1'b0, 4'd2},
    {4'h2, 4'hF, 1'b0, 1'b1, 4'd1},
    {4'h8, 4'h6, 1'b1, 1'b0, 4'd1}
  };

  task automatic do_write(input logic [3:0] a, input logic [3:0] d, input logic hi,
                          input logic lon, input int len, input logic clash);
    int f0;
    logic ok;
    logic [15:0] exp;
    ok  = hi && !lon && !clash;
    exp = ok ? (16'h1 << a) : 16'h0;
    f0  = fires;
    @(negedge clk);
    ale = 1'b1; addr = a; din = d; cs_hi = hi; cs_lo_n = lon; wr_n = 1'b0;
    rd_n = clash ? 1'b0 : 1'b1;
    #1;
    if (clash) chk("R8 oe during clash", oe, 0);
    for (int k = 1; k < len; k++) begin
      @(negedge clk); #1;
      chk("R6 no enable mid-pulse", wr_en, 0);
    end
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); #1;
    chk(ok ? "R4 R5 enable" : (clash ? "R8 dropped" : "R3 R9 unselected"), wr_en, exp);
    if (ok) chk("R5 data", wdata, d);
    @(negedge clk); #1;
    chk("R6 pulse count", fires - f0, ok ? 1 : 0);
    cs_hi = 1'b0; cs_lo_n = 1'b1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 wr_en in reset", wr_en, 0);
    chk("R1 oe in reset", oe, 0);
    chk("R1 wdata in reset", wdata, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 wr_en after reset", wr_en, 0);

    foreach (VEC[i])
      do_write(VEC[i][13:10], VEC[i][9:6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), 1'b0);

    // R8: read overlapping a write
    do_write(4'h6, 4'h1, 1'b1, 1'b0, 2, 1'b1);

    // R2: transparency and hold
    @(negedge clk); ale = 1'b1; addr = 4'h5; #1;
    chk("R2 transparent", rd_sel, 4'h5);
    @(negedge clk); ale = 1'b0; addr = 4'h9; #1;
    chk("R2 hold", rd_sel, 4'h5);
    @(negedge clk); #1;
    chk("R2 hold next cycle", rd_sel, 4'h5);
    ale = 1'b1; #1;
    chk("R2 reopen", rd_sel, 4'h9);

    // R2 R5: write with latched address, bus address changed
    @(negedge clk); addr = 4'h3;
    @(negedge clk); ale = 1'b0; addr = 4'h7; cs_hi = 1'b1; cs_lo_n = 1'b0; din = 4'hB; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); #1;
    chk("R2 write uses latched address", wr_en, 16'h0008);

    // R5: data changing inside the pulse, last active edge wins
    @(negedge clk); ale = 1'b1; addr = 4'hD; din = 4'h1; wr_n = 1'b0;
    @(negedge clk); din = 4'h2;
    @(negedge clk); wr_n = 1'b1; din = 4'h3;
    @(negedge clk); #1;
    chk("R5 last-active data", wdata, 4'h2);
    chk("R5 enable", wr_en, 16'h2000);

    // R9: select dropped on the last active edge
    @(negedge clk); addr = 4'h1; wr_n = 1'b0;
    @(negedge clk); cs_hi = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 late deselect", wr_en, 0);

    // R7: reads
    @(negedge clk); ale = 1'b1; addr = 4'hE; cs_hi = 1'b1; cs_lo_n = 1'b0; rd_n = 1'b0; #1;
    chk("R7 oe", oe, 1);
    chk("R7 data", dout, 4'hE ^ 4'hA);
    addr = 4'h0; #1;
    chk("R7 data addr 0", dout, 4'h0 ^ 4'hA);
    cs_lo_n = 1'b1; #1;
    chk("R3 oe cs_lo high", oe, 0);
    chk("R7 data released", dout, 0);
    cs_lo_n = 1'b0; cs_hi = 1'b0; #1;
    chk("R3 oe cs_hi low", oe, 0);
    @(negedge clk); rd_n = 1'b1; #1;
    chk("R7 oe idle", oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule